// File: doc/BRIEF.md
# Branch String Predictor with Fallback

This block predicts the direction of conditional branches for the packet currently being handled by a packet processing engine. At the start of a packet, an external key-matching table reports whether the packet's header key was seen before (`pkt_hit`) and which table slot belongs to it (`pkt_entry`). On a miss, the slot is the one just allocated for the key. On a hit, the block loads that slot's stored direction string into a per-packet register. It then answers each branch request with the next unused bit of the string. The prediction does not depend on the branch address.

A fallback gshare predictor answers every request when the packet missed, when no packet is open, and once a hit packet has consumed every bit of its string. The table of 2-bit counters and the string register are read in parallel on every request. Only the string register's state chooses which answer drives `pred_taken`; there is no chooser table.

Every resolved outcome trains the fallback predictor. While the packet is open, the outcome is also written into the string register at the current position. When the packet ends, or when the register fills, the register is written back to the packet's slot. The next packet with the same key then replays the most recent path.

Top module: `branch_string_predictor`

## Requirements
- R1: After reset every fallback counter holds 1 (weakly not-taken), the history register holds zero and every string slot is all zeros. The first predictions are therefore not-taken, and a hit on an untouched slot also predicts not-taken.
- R2: After `pkt_start` with `pkt_hit`=1, request number k of the packet (counting from 0, k < STR_BITS) is predicted by bit k of the selected slot. `pred_taken` is valid combinationally in the request cycle.
- R3: In a hit packet, request number STR_BITS and every later request is predicted by the fallback predictor.
- R4: In a miss packet, and while no packet is open, every request is predicted by the fallback predictor.
- R5: The fallback index is `br_pc[PC_LSB +: log2(PHT_ENTRIES)]` XOR the history, captured in the request cycle. On every resolve, the history shifts left and the resolved outcome enters at bit 0.
- R6: On every resolve, the counter at the captured index moves up (taken) or down (not-taken), saturating at 0 and 3. This happens whichever source made the prediction. The fallback predicts taken when its counter is 2 or 3.
- R7: At `pkt_end`, the packet's slot is rewritten. If k branches resolved, bits 0..k-1 hold their outcomes in order. The remaining bits keep the loaded string (hit) or are zero (miss).
- R8: The resolve of branch number STR_BITS-1 writes the slot in that cycle. Later outcomes of the packet are not recorded, and the following `pkt_end` writes nothing.
- R9: A resolve in the same cycle as `pkt_end` is included in the written string.
- R10: When `pkt_end` and a hit `pkt_start` on the same slot fall in one cycle, the new packet replays the string written by the ending one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_start | input | 1 | Opens a packet; samples `pkt_hit` and `pkt_entry` |
| pkt_hit | input | 1 | Key match found for the new packet |
| pkt_entry | input | log2(N_ENTRIES) | Slot matched or allocated for the packet |
| pkt_end | input | 1 | Closes the packet and triggers write-back |
| br_req | input | 1 | Conditional branch prediction request |
| br_pc | input | PC_W | Address of the requesting branch |
| pred_taken | output | 1 | Predicted direction, valid with `br_req` |
| br_resolve | input | 1 | Outcome of the outstanding branch is known |
| br_taken | input | 1 | Resolved direction, valid with `br_resolve` |

## Verification
Two pairs of events can share a cycle. The last resolve of a packet can arrive together with `pkt_end`, and the close of one packet can arrive together with the hit start of the next on the same slot. The bench provokes both: the first as the final step of a short miss packet, the second as a back-to-back handover. It judges each by replaying the affected slot on a later hit packet and comparing every prediction against a behavioural model that applies resolve, write-back and load in that order. The fill case, where the write happens mid-packet, is driven with a packet longer than the string.

// File: rtl/strpred_pkg.sv
package strpred_pkg;

    typedef logic [1:0] ctr2_t;

    localparam ctr2_t CTR_WEAK_NT = 2'b01;

    typedef struct packed {
        logic valid;
        logic taken;
    } outcome_t;

    typedef enum logic {
        SRC_FALLBACK = 1'b0,
        SRC_STRING   = 1'b1
    } pred_src_e;

    function automatic ctr2_t ctr_step(ctr2_t c, logic taken);
        if (taken) return (c == 2'b11) ? c : c + 2'd1;
        return (c == 2'b00) ? c : c - 2'd1;
    endfunction

    function automatic logic ctr_dir(ctr2_t c);
        return c[1];
    endfunction

endpackage

// File: rtl/strpred_gshare.sv
module strpred_gshare
    import strpred_pkg::*;
#(
    parameter int PHT_ENTRIES = 128,
    parameter int PC_W        = 32,
    parameter int PC_LSB      = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req,
    input  logic [PC_W-1:0] pc,
    input  outcome_t        res,
    output logic            pred
);
    localparam int IDX_W = $clog2(PHT_ENTRIES);

    ctr2_t            pht_q [PHT_ENTRIES];
    logic [IDX_W-1:0] hist_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_now;
    ctr2_t            upd_ctr;
    logic             unused_pc_bits;

    assign idx_now        = pc[PC_LSB +: IDX_W] ^ hist_q;
    assign pred           = ctr_dir(pht_q[idx_now]);
    assign upd_ctr        = pht_q[idx_q];
    assign unused_pc_bits = ^{pc[PC_LSB-1:0], pc[PC_W-1:PC_LSB+IDX_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PHT_ENTRIES; i++) pht_q[i] <= CTR_WEAK_NT;
            hist_q <= '0;
            idx_q  <= '0;
        end else begin
            if (req) idx_q <= idx_now;
            if (res.valid) begin
                pht_q[idx_q] <= ctr_step(upd_ctr, res.taken);
                hist_q       <= {hist_q[IDX_W-2:0], res.taken};
            end
        end
    end

    assert_hist_shift_R5: assert property (@(posedge clk) disable iff (rst)
        res.valid |=> (hist_q[0] == $past(res.taken)) &&
                      (hist_q[IDX_W-1:1] == $past(hist_q[IDX_W-2:0])));

    assert_ctr_up_R6: assert property (@(posedge clk) disable iff (rst)
        (res.valid && res.taken) |=>
            pht_q[$past(idx_q)] == (($past(upd_ctr) == 2'b11) ? 2'b11 : $past(upd_ctr) + 2'd1));

    assert_ctr_down_R6: assert property (@(posedge clk) disable iff (rst)
        (res.valid && !res.taken) |=>
            pht_q[$past(idx_q)] == (($past(upd_ctr) == 2'b00) ? 2'b00 : $past(upd_ctr) - 2'd1));

endmodule

// File: rtl/strpred_table.sv
module strpred_table #(
    parameter int N_ENTRIES = 16,
    parameter int STR_BITS  = 128
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [$clog2(N_ENTRIES)-1:0] wr_idx,
    input  logic [STR_BITS-1:0]          wr_data,
    input  logic [$clog2(N_ENTRIES)-1:0] rd_idx,
    output logic [STR_BITS-1:0]          rd_data
);
    logic [STR_BITS-1:0] mem_q [N_ENTRIES];

    // A write-back landing in the cycle of a load is forwarded.
    assign rd_data = (wr_en && (wr_idx == rd_idx)) ? wr_data : mem_q[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_ENTRIES; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    assert_wr_lands_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> mem_q[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/strpred_replay.sv
module strpred_replay
    import strpred_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    parameter int STR_BITS  = 128
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         pkt_start,
    input  logic                         pkt_hit,
    input  logic [$clog2(N_ENTRIES)-1:0] pkt_entry,
    input  logic                         pkt_end,
    input  outcome_t                     res,
    input  logic [STR_BITS-1:0]          rd_data,
    output logic                         str_valid,
    output logic                         str_bit,
    output logic                         wr_en,
    output logic [$clog2(N_ENTRIES)-1:0] wr_idx,
    output logic [STR_BITS-1:0]          wr_data
);
    localparam int EW = $clog2(N_ENTRIES);
    localparam int CW = $clog2(STR_BITS + 1);
    localparam int BW = $clog2(STR_BITS);
    localparam logic [CW-1:0] FULL = CW'(STR_BITS);
    localparam logic [CW-1:0] LAST = CW'(STR_BITS - 1);

    logic [STR_BITS-1:0] rec_q, rec_next;
    logic [CW-1:0]       cnt_q;
    logic [EW-1:0]       ent_q;
    logic                active_q, replay_q;
    logic [BW-1:0]       pos;
    logic                room, rec_ok, fill;

    assign pos    = cnt_q[BW-1:0];
    assign room   = cnt_q < FULL;
    assign rec_ok = res.valid && active_q && room;
    assign fill   = rec_ok && (cnt_q == LAST);

    always_comb begin
        rec_next = rec_q;
        if (rec_ok) rec_next[pos] = res.taken;
    end

    assign str_valid = active_q && replay_q && room;
    assign str_bit   = rec_q[pos];
    assign wr_en     = fill || (pkt_end && active_q && room);
    assign wr_idx    = ent_q;
    assign wr_data   = rec_next;

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q    <= '0;
            cnt_q    <= '0;
            ent_q    <= '0;
            active_q <= 1'b0;
            replay_q <= 1'b0;
        end else if (pkt_start) begin
            active_q <= 1'b1;
            replay_q <= pkt_hit;
            ent_q    <= pkt_entry;
            cnt_q    <= '0;
            rec_q    <= pkt_hit ? rd_data : '0;
        end else begin
            if (pkt_end) active_q <= 1'b0;
            if (rec_ok) begin
                rec_q <= rec_next;
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL);

    assert_hit_load_R2: assert property (@(posedge clk) disable iff (rst)
        (pkt_start && pkt_hit) |=> (replay_q && active_q && cnt_q == '0));

endmodule

// File: rtl/branch_string_predictor.sv
module branch_string_predictor
    import strpred_pkg::*;
#(
    parameter int N_ENTRIES   = 16,
    parameter int STR_BITS    = 128,
    parameter int PHT_ENTRIES = 128,
    parameter int PC_W        = 32,
    parameter int PC_LSB      = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         pkt_start,
    input  logic                         pkt_hit,
    input  logic [$clog2(N_ENTRIES)-1:0] pkt_entry,
    input  logic                         pkt_end,
    input  logic                         br_req,
    input  logic [PC_W-1:0]              br_pc,
    output logic                         pred_taken,
    input  logic                         br_resolve,
    input  logic                         br_taken
);
    localparam int EW = $clog2(N_ENTRIES);

    outcome_t            res;
    logic                gs_pred, str_valid, str_bit, wr_en;
    logic [EW-1:0]       wr_idx;
    logic [STR_BITS-1:0] wr_data, rd_data;
    pred_src_e           src;

    assign res = '{valid: br_resolve, taken: br_taken};

    strpred_gshare #(
        .PHT_ENTRIES(PHT_ENTRIES), .PC_W(PC_W), .PC_LSB(PC_LSB)
    ) u_fallback (
        .clk(clk), .rst(rst), .req(br_req), .pc(br_pc), .res(res), .pred(gs_pred)
    );

    strpred_table #(
        .N_ENTRIES(N_ENTRIES), .STR_BITS(STR_BITS)
    ) u_table (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(pkt_entry), .rd_data(rd_data)
    );

    strpred_replay #(
        .N_ENTRIES(N_ENTRIES), .STR_BITS(STR_BITS)
    ) u_replay (
        .clk(clk), .rst(rst), .pkt_start(pkt_start), .pkt_hit(pkt_hit),
        .pkt_entry(pkt_entry), .pkt_end(pkt_end), .res(res), .rd_data(rd_data),
        .str_valid(str_valid), .str_bit(str_bit), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data)
    );

    assign src        = str_valid ? SRC_STRING : SRC_FALLBACK;
    assign pred_taken = (src == SRC_STRING) ? str_bit : gs_pred;

endmodule

// File: tb/branch_string_predictor_tb_top.sv
module branch_string_predictor_tb_top;
    localparam int N = 16, M = 128, P = 128;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst, pkt_start, pkt_hit, pkt_end, br_req, br_resolve, br_taken, pred_taken;
    logic [3:0]  pkt_entry;
    logic [31:0] br_pc;

    branch_string_predictor dut_i (
        .clk(clk), .rst(rst), .pkt_start(pkt_start), .pkt_hit(pkt_hit),
        .pkt_entry(pkt_entry), .pkt_end(pkt_end), .br_req(br_req), .br_pc(br_pc),
        .pred_taken(pred_taken), .br_resolve(br_resolve), .br_taken(br_taken)
    );

    int n_chk = 0, n_bad = 0;

    // behavioural reference state
    int          m_pht [P];
    int          m_hist, m_idx, m_cnt, m_ent;
    bit          m_active, m_replay;
    logic [M-1:0] m_tbl [N];
    logic [M-1:0] m_rec;

    function automatic int gidx(logic [31:0] pc);
        return (int'(pc >> 2) & (P - 1)) ^ m_hist;
    endfunction

    function automatic logic model_pred(logic [31:0] pc);
        if (m_active && m_replay && m_cnt < M) return m_rec[m_cnt];
        return (m_pht[gidx(pc)] >= 2);
    endfunction

    task automatic check(string tag, logic got, logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: pred_taken=%b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_update(bit s, bit h, int e, bit en, bit rq, logic [31:0] pc, bit rs, bit tk);
        int pre = m_cnt;
        if (rq) m_idx = gidx(pc);
        if (rs) begin
            if (tk) m_pht[m_idx] = (m_pht[m_idx] == 3) ? 3 : m_pht[m_idx] + 1;
            else    m_pht[m_idx] = (m_pht[m_idx] == 0) ? 0 : m_pht[m_idx] - 1;
            m_hist = ((m_hist << 1) | int'(tk)) & (P - 1);
            if (m_active && m_cnt < M) begin
                m_rec[m_cnt] = tk;
                if (m_cnt == M - 1) m_tbl[m_ent] = m_rec;
                m_cnt++;
            end
        end
        if (en && m_active && pre < M) m_tbl[m_ent] = m_rec;
        if (en) m_active = 0;
        if (s) begin
            m_active = 1; m_replay = h; m_ent = e; m_cnt = 0;
            m_rec = h ? m_tbl[e] : '0;
        end
    endtask

    task automatic step(bit s, bit h, int e, bit en, bit rq, logic [31:0] pc, bit rs, bit tk, string tag);
        pkt_start = s; pkt_hit = h; pkt_entry = 4'(e); pkt_end = en;
        br_req = rq; br_pc = pc; br_resolve = rs; br_taken = tk;
        #1;
        if (rq) check(tag, pred_taken, model_pred(pc));
        @(posedge clk);
        model_update(s, h, e, en, rq, pc, rs, tk);
        @(negedge clk);
        pkt_start = 0; pkt_hit = 0; pkt_end = 0; br_req = 0; br_resolve = 0; br_taken = 0;
    endtask

    task automatic branch(logic [31:0] pc, bit tk, string tag, bit close = 0);
        step(0, 0, 0, 0, 1, pc, 0, 0, tag);
        step(0, 0, 0, close, 0, 32'h0, 1, tk, tag);
    endtask

    task automatic open_pkt(bit h, int e);
        step(1, h, e, 0, 0, 32'h0, 0, 0, "start");
    endtask

    task automatic close_pkt();
        step(0, 0, 0, 1, 0, 32'h0, 0, 0, "end");
    endtask

    function automatic logic [31:0] pc_of(int i);
        return 32'h400 + 32'(((i * 37) % 64) * 4);
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        #(8 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run not finished, actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        rst = 1; pkt_start = 0; pkt_hit = 0; pkt_entry = 0; pkt_end = 0;
        br_req = 0; br_pc = 0; br_resolve = 0; br_taken = 0;
        for (int i = 0; i < P; i++) m_pht[i] = 1;
        for (int i = 0; i < N; i++) m_tbl[i] = '0;
        m_hist = 0; m_idx = 0; m_cnt = 0; m_ent = 0; m_active = 0; m_replay = 0; m_rec = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;

        // R1: reset state, fallback and untouched slot both not-taken
        branch(32'h100, 1, "R1");
        open_pkt(1, 3);
        for (int i = 0; i < 6; i++) branch(pc_of(i), i[0], "R1");
        close_pkt();

        // R5/R6: no packet open, varied addresses then one address saturating
        for (int i = 0; i < 24; i++) branch(pc_of(i + 3), (i % 3) != 0, "R5");
        for (int i = 0; i < 14; i++) branch(32'h2A0, 1, "R6");
        for (int i = 0; i < 5; i++)  branch(32'h2A0, 0, "R6");

        // R4: miss packet on slot 5
        open_pkt(0, 5);
        for (int i = 0; i < 40; i++) branch(pc_of(i), (i % 3) == 0, "R4");
        close_pkt();

        // R2/R7: hit replay of slot 5, then further outcomes diverge
        open_pkt(1, 5);
        for (int i = 0; i < 50; i++) branch(pc_of(i), ((i % 3) == 0) ^ ((i % 7) == 0), "R2");
        close_pkt();
        open_pkt(1, 5);
        for (int i = 0; i < 60; i++) branch(pc_of(i + 1), (i % 2) == 0, "R7");
        close_pkt();

        // R8/R3: overflowing miss packet on slot 9, then hit replay past the end
        open_pkt(0, 9);
        for (int i = 0; i < M + 7; i++) branch(pc_of(i), (i % 5) < 2, "R8");
        close_pkt();
        open_pkt(1, 9);
        for (int i = 0; i < M + 7; i++) branch(pc_of(i + 2), (i % 4) == 1, "R3");
        close_pkt();

        // R9: final resolve shares the cycle with pkt_end
        open_pkt(0, 2);
        for (int i = 0; i < 9; i++) branch(pc_of(i), 1, "R9");
        branch(pc_of(9), 1, "R9", 1);
        open_pkt(1, 2);
        for (int i = 0; i < 12; i++) branch(pc_of(i), 0, "R9");
        close_pkt();

        // R10: close of one packet and hit start on the same slot in one cycle
        open_pkt(0, 4);
        for (int i = 0; i < 8; i++) branch(pc_of(i + 5), (i % 2) == 1, "R10");
        step(1, 1, 4, 1, 0, 32'h0, 0, 0, "R10");
        for (int i = 0; i < 10; i++) branch(pc_of(i + 5), 1, "R10");
        close_pkt();

        summary();
        $finish;
    end
endmodule